// File: doc/BRIEF.md
# Banked Memory Width and Depth Expander

This block builds one larger read/write memory out of identical small banks. Each bank stores 2^K words that are each four bits wide. Banks placed side by side in a row all receive the same address, and each one holds one nibble lane of the wide word. Rows are stacked to add depth. The most significant address bits decode into one chip select per row, and that chip select is gated by the global chip select. With the default settings there are four banks in two rows of two, which gives a memory of 2^(K+1) bytes.

Writes take effect on the clock edge when chip select and write enable are both high. A read is requested on an edge when chip select is high and write enable is low. The addressed byte appears on the read port one cycle after that edge and stays there until the next read. Only the row captured by the most recent read drives the read port.

Top module: `memx_expand`

## Requirements
- R1: Every address in the full space of 2^(K+ROW_BITS) words keeps an 8-bit word written to it and returns that word when read. The composite memory behaves exactly like a single flat memory of the same size.
- R2: The upper address bit (bit K) selects the row. Writing address A does not change address A XOR 2^K, which shares the same low bits.
- R3: When cs is low, a write has no effect on stored data and no bank is enabled.
- R4: Data read on the edge where cs=1 and we=0 is present on rd_data after that edge. It is sampled in the following cycle.
- R5: rd_data does not change on cycles without a read request, whether the cycle is a write or a deselected cycle.
- R6: rd_data[3:0] comes from the low-nibble bank of the row and rd_data[7:4] from the high-nibble bank. The two nibbles are stored independently.
- R7: While reset is asserted and after it is released, rd_data is 0 until the first read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Global chip select |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | K+ROW_BITS | Word address; the top ROW_BITS bits select the row |
| wr_data | input | 4*LANES | Write data, split into nibble lanes |
| rd_data | output | 4*LANES | Read data from the last read row |

## Verification
On every cycle the assertions check three things: at most one row chip select is active, no row is enabled while the global select is low, and the active row matches the upper address bit. They also check that rd_data stays stable whenever the previous edge carried no read. Data integrity cannot be seen on a single cycle, so it is left to the bench scenarios. Those cover the exhaustive comparison against a flat reference model, aliasing between rows, nibble independence, and deselected writes that must leave memory untouched.

// File: rtl/memx_pkg.sv
package memx_pkg;
  localparam int unsigned LANE_W = 4;

  function automatic int unsigned row_sel_w(input int unsigned row_bits);
    return (row_bits == 0) ? 1 : row_bits;
  endfunction
endpackage

// File: rtl/memx_bank.sv
module memx_bank #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q, rdata_d;
  logic          wr_en, rd_en;

  assign wr_en = cs && we;
  assign rd_en = cs && !we;

  // storage array: behavioural, not reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/memx_row_decode.sv
module memx_row_decode #(
  parameter int unsigned ROW_BITS = 1,
  parameter int unsigned SEL_W    = (ROW_BITS == 0) ? 1 : ROW_BITS,
  parameter int unsigned ROWS     = 1 << ROW_BITS
) (
  input  logic             cs,
  input  logic [SEL_W-1:0] row_addr,
  output logic [ROWS-1:0]  row_cs
);
  generate
    if (ROW_BITS == 0) begin : g_single
      logic unused_sel;
      assign unused_sel = ^row_addr;
      assign row_cs     = cs;
    end else begin : g_multi
      for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_cs[r] = cs && (row_addr == SEL_W'(r));
      end
    end
  endgenerate
endmodule

// File: rtl/memx_row.sv
module memx_row
  import memx_pkg::*;
#(
  parameter int unsigned AW    = 4,
  parameter int unsigned LANES = 2,
  parameter int unsigned DW    = LANES * LANE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    memx_bank #(.AW(AW), .DW(LANE_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .cs    (cs),
      .we    (we),
      .addr  (addr),
      .wdata (wdata[l*LANE_W +: LANE_W]),
      .rdata (rdata[l*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/memx_expand.sv
module memx_expand
  import memx_pkg::*;
#(
  parameter int unsigned BANK_AW  = 4,
  parameter int unsigned LANES    = 2,
  parameter int unsigned ROW_BITS = 1,
  localparam int unsigned AW      = BANK_AW + ROW_BITS,
  localparam int unsigned DW      = LANES * LANE_W,
  localparam int unsigned ROWS    = 1 << ROW_BITS,
  localparam int unsigned SEL_W   = (ROW_BITS == 0) ? 1 : ROW_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  logic [SEL_W-1:0] row_addr;
  logic [ROWS-1:0]  row_cs;
  logic [DW-1:0]    row_rd [ROWS];
  logic [SEL_W-1:0] sel_row_q, sel_row_d;

  generate
    if (ROW_BITS == 0) begin : g_flat
      assign row_addr = '0;
    end else begin : g_stack
      assign row_addr = addr[AW-1 -: ROW_BITS];
    end
  endgenerate

  memx_row_decode #(.ROW_BITS(ROW_BITS)) u_dec (
    .cs       (cs),
    .row_addr (row_addr),
    .row_cs   (row_cs)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    memx_row #(.AW(BANK_AW), .LANES(LANES)) u_row (
      .clk   (clk),
      .rst_n (rst_n),
      .cs    (row_cs[r]),
      .we    (we),
      .addr  (addr[BANK_AW-1:0]),
      .wdata (wr_data),
      .rdata (row_rd[r])
    );
  end

  always_comb begin
    sel_row_d = sel_row_q;
    if (cs && !we) sel_row_d = row_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_row_q <= '0;
    else        sel_row_q <= sel_row_d;
  end

  assign rd_data = row_rd[sel_row_q];
endmodule

// File: rtl/memx_expand_chk.sv
module memx_expand_chk #(
  parameter int unsigned AW       = 5,
  parameter int unsigned DW       = 8,
  parameter int unsigned ROWS     = 2,
  parameter int unsigned ROW_BITS = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs,
  input logic            we,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   rd_data,
  input logic [ROWS-1:0] row_cs
);
  p_one_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_cs));

  p_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> (row_cs == '0));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && !we) |=> $stable(rd_data));

  generate
    if (ROW_BITS > 0) begin : g_pick
      p_row_pick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs |-> (row_cs[addr[AW-1 -: ROW_BITS]] && $countones(row_cs) == 1));
    end
  endgenerate
endmodule

bind memx_expand memx_expand_chk #(
  .AW(AW), .DW(DW), .ROWS(ROWS), .ROW_BITS(ROW_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .we(we),
  .addr(addr), .rd_data(rd_data), .row_cs(row_cs)
);

// File: tb/memx_expand_tb.sv
`timescale 1ns/100ps
module memx_expand_tb;
  localparam int K  = 4;
  localparam int AW = K + 1;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n, cs, we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wr_data, rd_data;

  int compared = 0, mismatched = 0;
  logic [DW-1:0] ref_mem [N];

  typedef struct { logic [DW-1:0] exp; string req; } item_t;
  item_t q [$];

  always #2.5 clk = ~clk;

  memx_expand #(.BANK_AW(K), .LANES(2), .ROW_BITS(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string req);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: rd_data=%h expected=%h", req, got, exp);
    end
  endtask

  // monitor: compares queued expectations half a cycle after the edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(rd_data, it.exp, it.req);
    end
  end

  task automatic cyc(input logic c, input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cs = c; we = w; addr = a; wr_data = d;
    @(posedge clk);
    #1;
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(1'b1, 1'b1, a, d);
    ref_mem[a] = d;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    item_t it;
    cyc(1'b0 | 1'b1, 1'b0, a, 8'h00);
    it.exp = ref_mem[a]; it.req = req;
    q.push_back(it);
  endtask

  initial begin
    #200000;
    mismatched++; compared++;
    $display("FAIL watchdog: expired expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    item_t h;
    rst_n = 1'b0; cs = 1'b0; we = 1'b0; addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rd_data, 8'h00, "R7 in reset");
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check(rd_data, 8'h00, "R7 after reset");

    // R1/R6: fill every address with nibble-distinct bytes, read all back
    for (int a = 0; a < N; a++) wr(AW'(a), 8'(((a * 7 + 3) << 4) | ((~a) & 4'hF)));
    for (int a = 0; a < N; a++) rd(AW'(a), "R1 flat compare");

    // R2: alias across rows
    wr(5'h03, 8'hC3);
    wr(5'h13, 8'h3C);
    rd(5'h03, "R2 lower row kept");
    rd(5'h13, "R2 upper row");

    // R6: nibble independence
    wr(5'h07, 8'hF0); rd(5'h07, "R6 high nibble only");
    wr(5'h07, 8'h0F); rd(5'h07, "R6 low nibble only");
    wr(5'h1A, 8'h5A); rd(5'h1A, "R6 mixed nibbles");

    // R3: deselected write must not land
    cyc(1'b0, 1'b1, 5'h07, 8'hEE);
    rd(5'h07, "R3 deselected write ignored");
    cyc(1'b0, 1'b1, 5'h17, 8'hEE);
    rd(5'h17, "R3 deselected write ignored row1");

    // R4/R5: hold through write and idle cycles
    rd(5'h13, "R4 read latency");
    wr(5'h00, 8'h99);
    h.exp = ref_mem[5'h13]; h.req = "R5 hold after write"; q.push_back(h);
    cyc(1'b0, 1'b0, 5'h00, 8'h00);
    h.exp = ref_mem[5'h13]; h.req = "R5 hold when deselected"; q.push_back(h);
    rd(5'h00, "R4 new row after hold");

    // back-to-back reads alternating rows
    for (int a = 0; a < 8; a++) rd(AW'(a * 5), "R1 back-to-back");

    @(negedge clk); @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule